// File: doc/BRIEF.md
# Reconfigurable Broadcast Scan Chain

This block is a scan register whose cells are grouped into equal segments, four by default. Each segment has its own serial output. One shared serial input feeds the chain. The way that input reaches the segments can be changed between shift operations. In broadcast mode every segment head takes the shared bit, so all segments load in parallel and a full load takes only one segment length of shift cycles. In serial mode each segment head takes the tail of the segment before it, so the segments behave as one long chain and the last segment output carries the whole chain.

A dynamic selection mode overrides both of these. A per-segment control word picks, for each segment after the first, either the shared input or the previous tail. With scan-enable low, every cell loads its functional input in parallel, whatever the mode inputs say. The cell contents are always visible on the parallel functional output.

Top module: `bcast_scan_chain`

## Requirements
- R1: While `rstN` is low, every cell is cleared. After reset, `funcQ` and `scanOut` read all zero.
- R2: With `scanEn`=0, every cell loads its bit of `funcD` at the clock edge. `bcastMode`, `dynEn` and `segCtl` have no effect on the result.
- R3: Cell index i belongs to segment i / SEG_LEN. During a shift, each non-head cell takes the value of the cell one index below it. `scanOut[k]` always equals cell k*SEG_LEN+SEG_LEN-1.
- R4: During a shift, cell 0 (the head of segment 0) always takes `scanIn`.
- R5: With `scanEn`=1, `bcastMode`=1 and `dynEn`=0, every segment head takes `scanIn`. After SEG_LEN shifts, every segment holds the same bits, and `segCtl` is ignored.
- R6: With `scanEn`=1, `bcastMode`=0 and `dynEn`=0, the head of segment k takes the tail of segment k-1. The chain then shifts as one register of SEG_CNT*SEG_LEN cells. `scanOut[SEG_CNT-1]` presents the old contents from the highest cell downward, one per shift.
- R7: With `scanEn`=1 and `dynEn`=1, the head of segment k≥1 takes `scanIn` when `segCtl[k]`=1 and the tail of segment k-1 when it is 0. `bcastMode` and `segCtl[0]` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| scanEn | input | 1 | 1 = shift, 0 = parallel capture |
| bcastMode | input | 1 | 1 = broadcast, 0 = serial (used when dynEn=0) |
| dynEn | input | 1 | 1 = per-segment source chosen by segCtl |
| segCtl | input | SEG_CNT | Per-segment source select, 1 = shared input |
| scanIn | input | 1 | Shared serial input |
| funcD | input | SEG_CNT*SEG_LEN | Functional data captured when scanEn=0 |
| funcQ | output | SEG_CNT*SEG_LEN | Cell contents |
| scanOut | output | SEG_CNT | Per-segment serial outputs |

## Verification
The bench builds the block with four segments of three cells each. That makes twelve cells, so every one of the 4096 capture values can be applied while the mode inputs change underneath. At this size a full serial load and a full broadcast load are short enough to repeat for many seeds and bit patterns. All sixteen control words can also be swept against both mode settings in dynamic selection.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef struct packed {
    logic shiftEn;
    logic captureEn;
  } bscStrobe_t;
endpackage

// File: rtl/bsc_ctrl.sv
module bsc_ctrl
  import bsc_pkg::*;
#(
  parameter int SEG_CNT = 4
) (
  input  logic               scanEn,
  input  logic               bcastMode,
  input  logic               dynEn,
  input  logic [SEG_CNT-1:0] segCtl,
  output bscStrobe_t         strobe,
  output logic [SEG_CNT-1:0] headFromPin
);
  always_comb begin
    strobe.shiftEn   = scanEn;
    strobe.captureEn = !scanEn;
  end

  // Mode inputs only matter while shifting; otherwise selects are parked.
  for (genvar k = 0; k < SEG_CNT; k++) begin : g_sel
    if (k == 0) begin : g_first
      assign headFromPin[k] = 1'b1;
    end else begin : g_rest
      assign headFromPin[k] = scanEn & (dynEn ? segCtl[k] : bcastMode);
    end
  end
endmodule

// File: rtl/bsc_datapath.sv
module bsc_datapath
  import bsc_pkg::*;
#(
  parameter int SEG_CNT = 4,
  parameter int SEG_LEN = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bscStrobe_t                 strobe,
  input  logic [SEG_CNT-1:0]         headFromPin,
  input  logic                       scanIn,
  input  logic [SEG_CNT*SEG_LEN-1:0] funcD,
  output logic [SEG_CNT*SEG_LEN-1:0] cellQ,
  output logic [SEG_CNT-1:0]         segTail
);
  localparam int CELLS = SEG_CNT * SEG_LEN;

  logic [CELLS-1:0] shiftSrc;

  for (genvar k = 0; k < SEG_CNT; k++) begin : g_seg
    localparam int BASE = k * SEG_LEN;
    if (k == 0) begin : g_head0
      assign shiftSrc[BASE] = scanIn;
    end else begin : g_headk
      assign shiftSrc[BASE] = headFromPin[k] ? scanIn : cellQ[BASE-1];
    end
    for (genvar i = 1; i < SEG_LEN; i++) begin : g_body
      assign shiftSrc[BASE+i] = cellQ[BASE+i-1];
    end
    assign segTail[k] = cellQ[BASE+SEG_LEN-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellQ <= '0;
    end else if (strobe.captureEn) begin
      cellQ <= funcD;
    end else if (strobe.shiftEn) begin
      cellQ <= shiftSrc;
    end
  end

  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    strobe.captureEn |=> cellQ == $past(funcD)); // R2

  AST_HEAD0_PIN: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    strobe.shiftEn |=> cellQ[0] == $past(scanIn)); // R4

  for (genvar k = 0; k < SEG_CNT; k++) begin : g_chk
    if (SEG_LEN > 1) begin : g_adv
      AST_SEG_ADVANCE: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
        strobe.shiftEn |=> cellQ[k*SEG_LEN+1 +: SEG_LEN-1] == $past(cellQ[k*SEG_LEN +: SEG_LEN-1])); // R3
    end
  end
endmodule

// File: rtl/bcast_scan_chain.sv
module bcast_scan_chain
  import bsc_pkg::*;
#(
  parameter int SEG_CNT = 4,
  parameter int SEG_LEN = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       scanEn,
  input  logic                       bcastMode,
  input  logic                       dynEn,
  input  logic [SEG_CNT-1:0]         segCtl,
  input  logic                       scanIn,
  input  logic [SEG_CNT*SEG_LEN-1:0] funcD,
  output logic [SEG_CNT*SEG_LEN-1:0] funcQ,
  output logic [SEG_CNT-1:0]         scanOut
);
  bscStrobe_t         strobe;
  logic [SEG_CNT-1:0] headFromPin;

  bsc_ctrl #(.SEG_CNT(SEG_CNT)) u_ctrl (
    .scanEn      (scanEn),
    .bcastMode   (bcastMode),
    .dynEn       (dynEn),
    .segCtl      (segCtl),
    .strobe      (strobe),
    .headFromPin (headFromPin)
  );

  bsc_datapath #(.SEG_CNT(SEG_CNT), .SEG_LEN(SEG_LEN)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .headFromPin (headFromPin),
    .scanIn      (scanIn),
    .funcD       (funcD),
    .cellQ       (funcQ),
    .segTail     (scanOut)
  );

  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  for (genvar k = 1; k < SEG_CNT; k++) begin : g_heads
    AST_BCAST_HEAD: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
      (scanEn && bcastMode && !dynEn) |=> funcQ[k*SEG_LEN] == $past(scanIn)); // R5
    AST_SERIAL_LINK: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
      (scanEn && !bcastMode && !dynEn) |=> funcQ[k*SEG_LEN] == $past(scanOut[k-1])); // R6
    AST_DYN_SELECT: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
      (scanEn && dynEn) |=> funcQ[k*SEG_LEN] == $past(segCtl[k] ? scanIn : scanOut[k-1])); // R7
  end
endmodule

// File: tb/sim_bcast_scan_chain.sv
`timescale 1ns/1ps
module sim_bcast_scan_chain;
  localparam int SC = 4;
  localparam int SL = 3;
  localparam int NC = SC * SL;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          scanEn = 1'b0;
  logic          bcastMode = 1'b0;
  logic          dynEn = 1'b0;
  logic [SC-1:0] segCtl = '0;
  logic          scanIn = 1'b0;
  logic [NC-1:0] funcD = '0;
  logic [NC-1:0] funcQ;
  logic [SC-1:0] scanOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bcast_scan_chain #(.SEG_CNT(SC), .SEG_LEN(SL)) u0 (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .bcastMode(bcastMode),
    .dynEn(dynEn), .segCtl(segCtl), .scanIn(scanIn), .funcD(funcD),
    .funcQ(funcQ), .scanOut(scanOut)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Expected segment outputs from a cell image: top cell of each segment.
  function automatic logic [SC-1:0] tails(logic [NC-1:0] v);
    logic [SC-1:0] t;
    for (int k = 0; k < SC; k++) t[k] = v[k*SL+SL-1];
    return t;
  endfunction

  // One shift step as the requirements define it.
  function automatic logic [NC-1:0] stepNext(logic [NC-1:0] cur, logic sin,
                                             logic bm, logic de, logic [SC-1:0] ctl);
    logic [NC-1:0] n;
    n = cur << 1;
    for (int k = 0; k < SC; k++) begin
      if (k == 0) n[0] = sin;
      else if (de ? ctl[k] : bm) n[k*SL] = sin;
      else n[k*SL] = cur[k*SL-1];
    end
    return n;
  endfunction

  task automatic capture(logic [NC-1:0] v);
    scanEn = 1'b0;
    funcD = v;
    tick();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NC-1:0] model;
    logic [NC-1:0] seed;
    logic [NC-1:0] pat;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 funcQ after reset", 32'(funcQ), 32'd0);
    chk("R1 scanOut after reset", 32'(scanOut), 32'd0);
    rstN = 1'b1;
    tick();
    chk("R1 held after release", 32'(funcQ), 32'd0);

    // R2: every capture value, mode inputs scrambled.
    for (int v = 0; v < (1 << NC); v++) begin
      bcastMode = v[0];
      dynEn = v[1];
      segCtl = SC'(v >> 2);
      scanIn = v[6];
      capture(NC'(v));
      chk("R2 capture", 32'(funcQ), 32'(v));
      chk("R3 tail positions", 32'(scanOut), 32'(tails(NC'(v))));
    end

    // R6: full serial load, old contents stream out of the last segment.
    for (int p = 0; p < 64; p++) begin
      seed = NC'(p * 193 + 41);
      pat = NC'(p * 77 + 5);
      segCtl = SC'(p);
      capture(seed);
      scanEn = 1'b1;
      bcastMode = 1'b0;
      dynEn = 1'b0;
      for (int j = 0; j < NC; j++) begin
        chk("R6 chain output order", 32'(scanOut[SC-1]), 32'(seed[NC-1-j]));
        scanIn = pat[j];
        tick();
      end
      for (int i = 0; i < NC; i++) model[i] = pat[NC-1-i];
      chk("R6 serial load image", 32'(funcQ), 32'(model));
    end

    // R5 and R4: broadcast load of SL bits, segCtl ignored.
    for (int b = 0; b < (1 << SL); b++) begin
      for (int s = 0; s < 4; s++) begin
        seed = NC'(b * 311 + s * 1021 + 7);
        capture(seed);
        scanEn = 1'b1;
        bcastMode = 1'b1;
        dynEn = 1'b0;
        segCtl = SC'(s * 5 + b);
        for (int j = 0; j < SL; j++) begin
          scanIn = b[j];
          tick();
          chk("R4 head0 takes input", 32'(funcQ[0]), 32'(b[j]));
        end
        for (int k = 0; k < SC; k++)
          for (int i = 0; i < SL; i++) model[k*SL+i] = b[SL-1-i];
        chk("R5 broadcast image", 32'(funcQ), 32'(model));
        chk("R5 all outputs equal", 32'(scanOut), b[0] ? 32'((1 << SC) - 1) : 32'd0);
      end
    end

    // R7: dynamic selection, all control words, both mode values.
    for (int c = 0; c < (1 << SC); c++) begin
      for (int m = 0; m < 2; m++) begin
        seed = NC'(c * 257 + m * 1365 + 90);
        pat = NC'(c * 37 + m * 11 + 969);
        capture(seed);
        model = seed;
        scanEn = 1'b1;
        dynEn = 1'b1;
        bcastMode = m[0];
        segCtl = SC'(c);
        for (int j = 0; j < NC; j++) begin
          scanIn = pat[j];
          tick();
          model = stepNext(model, pat[j], m[0], 1'b1, SC'(c));
          chk("R7 dynamic shift", 32'(funcQ), 32'(model));
          chk("R3 dynamic tails", 32'(scanOut), 32'(tails(model)));
        end
      end
    end

    // R3: mixed-mode shifting, switching mode every cycle.
    model = funcQ;
    for (int j = 0; j < 200; j++) begin
      scanEn = 1'b1;
      bcastMode = j[1];
      dynEn = j[3] & j[0];
      segCtl = SC'(j * 3);
      scanIn = j[2] ^ j[4];
      tick();
      model = stepNext(model, j[2] ^ j[4], j[1], j[3] & j[0], SC'(j * 3));
      chk("R3 mixed shift", 32'(funcQ), 32'(model));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule